// File: doc/BRIEF.md
# ROM-Socket Mailbox Bridge

This block takes the place of a parallel ROM on an 8-bit host processor's bus. The local controller fills a 64-byte outgoing window through a write port. The window holds boot code, control values, tone-generator notes, a one-shot command byte and the three-byte interrupt vectors. The host reads these bytes while chip-select and output-enable are both low.

The socket carries no write strobe, so the host signals a write by raising one address bit. An access with that bit high stores the data-bus byte in a small inbound mailbox, and the bridge leaves the data bus undriven. The controller reads the mailbox through a slot-indexed port. Each slot reports whether it holds unread data and whether a write was lost.

Interrupt activity on the host is recovered without any interrupt wire. When the host fetches the first (opcode) byte of a vector, the bridge sends the controller a one-cycle event pulse for that vector.

Top module: `mbx_rom_bridge`

## Requirements
- R1: A host read of a window offset (address bit 6 low, offsets 0x00 to 0x3F) drives the byte the local side last wrote there onto `bus_d_out`, with `bus_d_oe` high, two clock cycles after the access begins.
- R2: `bus_d_oe` is low two cycles after chip-select goes inactive, after output-enable goes inactive, or whenever the access has address bit 6 high.
- R3: A host access with address bit 6 high stores `bus_d_in` in inbound slot (address minus 0x40). There are slots 0 to 6. Slot 2 keeps only bit 0, and the other bits read as 0. Accesses to offsets 0x47 to 0x7F change no slot.
- R4: A host write sets the slot's new-data flag. A local read returns the flag on `lcl_rnew` one cycle later and clears it.
- R5: A second host write to a slot whose new-data flag is still set sets a sticky overrun bit, seen on `lcl_rovr`. A local read of the slot clears it.
- R6: The start of a host read at 0x2C, 0x34 or 0x3C produces a single one-cycle pulse on `evt_seq_tick`, `evt_midi_rx` or `evt_mod_tick` respectively, two cycles after the access begins. A pulse fires once per access, even if the access is held. Reads of other offsets, including 0x2D, produce no pulse.
- R7: Reads of offsets 0x20 to 0x27 return bit 7 as 0, whatever was written there.
- R8: Offset 0x28 is a command byte. The first host read returns it, after which it reads as 0 until the local side writes it again. A local write in the same cycle as that clear wins.
- R9: After reset, `bus_d_oe` and all event outputs are low, every slot reads data 0 with both flags clear, and the command byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; host bus inputs are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Socket chip-select, active low |
| bus_oe_n | input | 1 | Socket output-enable, active low |
| bus_addr | input | 7 | Host address; bit 6 marks a pseudo-write |
| bus_d_in | input | 8 | Data bus as driven by the host |
| bus_d_out | output | 8 | Byte the bridge presents to the host |
| bus_d_oe | output | 1 | Drive enable for the data bus |
| lcl_we | input | 1 | Local write strobe into the outgoing window |
| lcl_waddr | input | 6 | Outgoing window offset |
| lcl_wdata | input | 8 | Byte to store |
| lcl_re | input | 1 | Local read strobe of an inbound slot |
| lcl_raddr | input | 3 | Inbound slot index |
| lcl_rdata | output | 8 | Slot data, valid the cycle after `lcl_re` |
| lcl_rnew | output | 1 | Slot held unread data at the read |
| lcl_rovr | output | 1 | Slot had lost a write at the read |
| evt_seq_tick | output | 1 | Pulse on fetch of the 0x2C vector opcode |
| evt_midi_rx | output | 1 | Pulse on fetch of the 0x34 vector opcode |
| evt_mod_tick | output | 1 | Pulse on fetch of the 0x3C vector opcode |

## Verification
Host reads are applied to plain control offsets, to tone-note offsets whose stored bytes have bit 7 set, to each vector opcode, and to a vector address byte. Together these separate correct data return, masking, the right event line, and the absence of spurious events. Accesses are held for an extra cycle, so a repeated pulse would show. Single writes, double writes, writes to the one-bit slot and writes above the slot range show whether the flag logic tells new data from lost data and leaves untouched slots alone. Command reads repeated after a reload, plus accesses with only one of the two enables active, show the one-shot clear and the drive gating.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W    = 8;
  localparam int WIN_AW    = 6;
  localparam int IN_SLOTS  = 7;
  localparam int NUM_VEC   = 3;
  localparam int VEC_BASE  = 'h2C;
  localparam int VEC_STEP  = 8;
  localparam int FLAG_SLOT = 2;

  localparam logic [WIN_AW-1:0] CMD_OFF  = 6'h28;
  localparam logic [WIN_AW-1:0] TG_FIRST = 6'h20;
  localparam logic [WIN_AW-1:0] TG_LAST  = 6'h27;

  typedef enum int {EV_SEQ = 0, EV_MIDI = 1, EV_MOD = 2} vec_ev_e;

  function automatic logic [WIN_AW-1:0] vec_offset(input int idx);
    return WIN_AW'(VEC_BASE + VEC_STEP * idx);
  endfunction
endpackage

// File: rtl/mbx_bus_front.sv
module mbx_bus_front #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic [AW:0]   addr,
  input  logic [DW-1:0] din,
  output logic          smp_wr,
  output logic [AW-1:0] smp_off,
  output logic [DW-1:0] smp_din,
  output logic          acc_start,
  output logic          d_oe
);
  logic smp_active, prev_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_active  <= 1'b0;
      prev_active <= 1'b0;
      smp_wr      <= 1'b0;
      smp_off     <= '0;
      smp_din     <= '0;
      d_oe        <= 1'b0;
    end else begin
      smp_active  <= !cs_n && !oe_n;
      prev_active <= smp_active;
      smp_wr      <= addr[AW];
      smp_off     <= addr[AW-1:0];
      smp_din     <= din;
      d_oe        <= smp_active && !smp_wr;
    end
  end

  assign acc_start = smp_active && !prev_active;

  assert_idle_undriven_R2: assert property (@(posedge clk) disable iff (rst)
    (cs_n || oe_n) |-> ##2 !d_oe);
  assert_pwrite_undriven_R2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !oe_n && addr[AW]) |-> ##2 !d_oe);
endmodule

// File: rtl/mbx_out_window.sv
module mbx_out_window
  import mbx_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lcl_we,
  input  logic [AW-1:0] lcl_waddr,
  input  logic [DW-1:0] lcl_wdata,
  input  logic [AW-1:0] rd_off,
  input  logic          rd_start,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ram_q, cmd_q, cmd_snap;
  logic          sel_cmd, sel_tg;
  logic          cmd_lwr, cmd_clr;

  always_ff @(posedge clk) begin
    if (lcl_we) mem[lcl_waddr] <= lcl_wdata;
    ram_q <= mem[rd_off];
  end

  assign cmd_lwr = lcl_we && (lcl_waddr == CMD_OFF);
  assign cmd_clr = rd_start && (rd_off == CMD_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      cmd_snap <= '0;
      sel_cmd  <= 1'b0;
      sel_tg   <= 1'b0;
    end else begin
      if (cmd_lwr)      cmd_q <= lcl_wdata;
      else if (cmd_clr) cmd_q <= '0;
      if (rd_start) cmd_snap <= cmd_q;
      sel_cmd <= (rd_off == CMD_OFF);
      sel_tg  <= (rd_off >= TG_FIRST) && (rd_off <= TG_LAST);
    end
  end

  always_comb begin
    if (sel_cmd)     rd_data = cmd_snap;
    else if (sel_tg) rd_data = {1'b0, ram_q[DW-2:0]};
    else             rd_data = ram_q;
  end

  assert_cmd_oneshot_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_clr && !cmd_lwr) |=> (cmd_q == '0));
  assert_tg_msb_R7: assert property (@(posedge clk) disable iff (rst)
    sel_tg |-> !rd_data[DW-1]);
endmodule

// File: rtl/mbx_in_mailbox.sv
module mbx_in_mailbox
  import mbx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 6,
  parameter int SLOTS = 7,
  localparam int IAW  = $clog2(SLOTS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_start,
  input  logic [AW-1:0]  wr_off,
  input  logic [DW-1:0]  wr_data,
  input  logic           lcl_re,
  input  logic [IAW-1:0] lcl_raddr,
  output logic [DW-1:0]  lcl_rdata,
  output logic           lcl_rnew,
  output logic           lcl_rovr
);
  logic [DW-1:0] data_q [SLOTS];
  logic [SLOTS-1:0] new_q, ovr_q;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic hit_w, hit_r;
    assign hit_w = wr_start && (wr_off == AW'(i));
    assign hit_r = lcl_re && (lcl_raddr == IAW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        data_q[i] <= '0;
        new_q[i]  <= 1'b0;
        ovr_q[i]  <= 1'b0;
      end else begin
        if (hit_w) begin
          if (i == FLAG_SLOT) data_q[i] <= {{(DW-1){1'b0}}, wr_data[0]};
          else                data_q[i] <= wr_data;
          new_q[i] <= 1'b1;
          ovr_q[i] <= new_q[i] && !hit_r;
        end else if (hit_r) begin
          new_q[i] <= 1'b0;
          ovr_q[i] <= 1'b0;
        end
      end
    end

    assert_ovr_implies_new_R5: assert property (@(posedge clk) disable iff (rst)
      ovr_q[i] |-> new_q[i]);
    assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
      (hit_r && !hit_w) |=> !new_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lcl_rdata <= '0;
      lcl_rnew  <= 1'b0;
      lcl_rovr  <= 1'b0;
    end else if (lcl_re) begin
      if (lcl_raddr < IAW'(SLOTS)) begin
        lcl_rdata <= data_q[lcl_raddr];
        lcl_rnew  <= new_q[lcl_raddr];
        lcl_rovr  <= ovr_q[lcl_raddr];
      end else begin
        lcl_rdata <= '0;
        lcl_rnew  <= 1'b0;
        lcl_rovr  <= 1'b0;
      end
    end
  end

  assert_flag_slot_bit_R3: assert property (@(posedge clk) disable iff (rst)
    data_q[FLAG_SLOT][DW-1:1] == '0);
endmodule

// File: rtl/mbx_vec_events.sv
module mbx_vec_events
  import mbx_pkg::*;
#(
  parameter int AW   = 6,
  parameter int NVEC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_start,
  input  logic [AW-1:0]   rd_off,
  output logic [NVEC-1:0] evt
);
  for (genvar i = 0; i < NVEC; i++) begin : g_vec
    always_ff @(posedge clk) begin
      if (rst) evt[i] <= 1'b0;
      else     evt[i] <= rd_start && (rd_off == vec_offset(i));
    end

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> !evt[i]);
  end

  assert_one_event_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(evt));
endmodule

// File: rtl/mbx_rom_bridge.sv
module mbx_rom_bridge
  import mbx_pkg::*;
#(
  parameter int DW       = mbx_pkg::DATA_W,
  parameter int AW       = mbx_pkg::WIN_AW,
  parameter int SLOTS    = mbx_pkg::IN_SLOTS,
  parameter int NVEC     = mbx_pkg::NUM_VEC,
  localparam int IAW     = $clog2(SLOTS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_cs_n,
  input  logic           bus_oe_n,
  input  logic [AW:0]    bus_addr,
  input  logic [DW-1:0]  bus_d_in,
  output logic [DW-1:0]  bus_d_out,
  output logic           bus_d_oe,
  input  logic           lcl_we,
  input  logic [AW-1:0]  lcl_waddr,
  input  logic [DW-1:0]  lcl_wdata,
  input  logic           lcl_re,
  input  logic [IAW-1:0] lcl_raddr,
  output logic [DW-1:0]  lcl_rdata,
  output logic           lcl_rnew,
  output logic           lcl_rovr,
  output logic           evt_seq_tick,
  output logic           evt_midi_rx,
  output logic           evt_mod_tick
);
  logic          smp_wr, acc_start;
  logic [AW-1:0] smp_off;
  logic [DW-1:0] smp_din;
  logic [NVEC-1:0] evt;

  mbx_bus_front #(.DW(DW), .AW(AW)) u_front (
    .clk(clk), .rst(rst), .cs_n(bus_cs_n), .oe_n(bus_oe_n),
    .addr(bus_addr), .din(bus_d_in),
    .smp_wr(smp_wr), .smp_off(smp_off), .smp_din(smp_din),
    .acc_start(acc_start), .d_oe(bus_d_oe)
  );

  mbx_out_window #(.DW(DW), .AW(AW)) u_win (
    .clk(clk), .rst(rst),
    .lcl_we(lcl_we), .lcl_waddr(lcl_waddr), .lcl_wdata(lcl_wdata),
    .rd_off(smp_off), .rd_start(acc_start && !smp_wr),
    .rd_data(bus_d_out)
  );

  mbx_in_mailbox #(.DW(DW), .AW(AW), .SLOTS(SLOTS)) u_mbox (
    .clk(clk), .rst(rst),
    .wr_start(acc_start && smp_wr), .wr_off(smp_off), .wr_data(smp_din),
    .lcl_re(lcl_re), .lcl_raddr(lcl_raddr),
    .lcl_rdata(lcl_rdata), .lcl_rnew(lcl_rnew), .lcl_rovr(lcl_rovr)
  );

  mbx_vec_events #(.AW(AW), .NVEC(NVEC)) u_evt (
    .clk(clk), .rst(rst),
    .rd_start(acc_start && !smp_wr), .rd_off(smp_off),
    .evt(evt)
  );

  assign evt_seq_tick = evt[int'(EV_SEQ)];
  assign evt_midi_rx  = evt[int'(EV_MIDI)];
  assign evt_mod_tick = evt[int'(EV_MOD)];

  assert_no_evt_on_write_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_start && smp_wr) |=> (evt == '0));
endmodule

// File: tb/sim_mbx_rom_bridge.sv
module sim_mbx_rom_bridge;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_cs_n = 1'b1, bus_oe_n = 1'b1;
  logic [6:0] bus_addr = '0;
  logic [7:0] bus_d_in = '0;
  logic [7:0] bus_d_out;
  logic       bus_d_oe;
  logic       lcl_we = 1'b0;
  logic [5:0] lcl_waddr = '0;
  logic [7:0] lcl_wdata = '0;
  logic       lcl_re = 1'b0;
  logic [2:0] lcl_raddr = '0;
  logic [7:0] lcl_rdata;
  logic       lcl_rnew, lcl_rovr;
  logic       evt_seq_tick, evt_midi_rx, evt_mod_tick;

  always #2 clk = ~clk;

  mbx_rom_bridge u0 (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
    .bus_addr(bus_addr), .bus_d_in(bus_d_in), .bus_d_out(bus_d_out),
    .bus_d_oe(bus_d_oe), .lcl_we(lcl_we), .lcl_waddr(lcl_waddr),
    .lcl_wdata(lcl_wdata), .lcl_re(lcl_re), .lcl_raddr(lcl_raddr),
    .lcl_rdata(lcl_rdata), .lcl_rnew(lcl_rnew), .lcl_rovr(lcl_rovr),
    .evt_seq_tick(evt_seq_tick), .evt_midi_rx(evt_midi_rx),
    .evt_mod_tick(evt_mod_tick)
  );

  // kinds: 0 data out, 1 drive enable, 2 {seq,midi,mod}, 3 slot data, 4 {new,ovr}
  typedef struct {int kind; int val; string req;} exp_t;
  exp_t scb[$];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic int observe(input int kind);
    case (kind)
      0: return int'(bus_d_out);
      1: return int'(bus_d_oe);
      2: return int'({evt_seq_tick, evt_midi_rx, evt_mod_tick});
      3: return int'(lcl_rdata);
      default: return int'({lcl_rnew, lcl_rovr});
    endcase
  endfunction

  task automatic expect_now(input int kind, input int val, input string req);
    exp_t e;
    e.kind = kind; e.val = val; e.req = req;
    scb.push_back(e);
  endtask

  // monitor: compares everything queued at this falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (scb.size() > 0) begin
        exp_t e;
        int act;
        e = scb.pop_front();
        act = observe(e.kind);
        n_chk++;
        if (act !== e.val) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", e.req, e.kind, act, e.val);
        end
      end
    end
  end

  task automatic lwrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    lcl_we = 1'b1; lcl_waddr = a; lcl_wdata = d;
    @(negedge clk);
    lcl_we = 1'b0;
  endtask

  task automatic host_read(input logic [5:0] off, input int exp_d, input int exp_ev, input string req);
    @(negedge clk);
    bus_cs_n = 1'b0; bus_oe_n = 1'b0; bus_addr = {1'b0, off};
    @(negedge clk);
    @(negedge clk);
    expect_now(0, exp_d, req);
    expect_now(1, 1, "R1");
    expect_now(2, exp_ev, "R6");
    @(negedge clk);
    expect_now(2, 0, "R6 once per access");
    bus_cs_n = 1'b1; bus_oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expect_now(1, 0, "R2 after release");
  endtask

  task automatic host_write(input logic [5:0] off, input logic [7:0] d);
    @(negedge clk);
    bus_cs_n = 1'b0; bus_oe_n = 1'b0; bus_addr = {1'b1, off}; bus_d_in = d;
    @(negedge clk);
    @(negedge clk);
    expect_now(1, 0, "R2 pseudo-write");
    expect_now(2, 0, "R6 no event on write");
    bus_cs_n = 1'b1; bus_oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic lread(input logic [2:0] slot, input int exp_d, input int exp_f, input string req);
    @(negedge clk);
    lcl_re = 1'b1; lcl_raddr = slot;
    @(negedge clk);
    lcl_re = 1'b0;
    expect_now(3, exp_d, req);
    expect_now(4, exp_f, req);
  endtask

  task automatic half_enable(input bit cs_only);
    @(negedge clk);
    bus_cs_n = 1'b0; bus_oe_n = 1'b0; bus_addr = 7'h2C;
    if (cs_only) bus_oe_n = 1'b1; else bus_cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    expect_now(1, 0, "R2 one enable inactive");
    expect_now(2, 0, "R6 no fetch without both enables");
    bus_cs_n = 1'b1; bus_oe_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    @(negedge clk);
    expect_now(1, 0, "R9 drive enable");
    expect_now(2, 0, "R9 events");
    lread(3'd0, 0, 0, "R9 slot 0");
    lread(3'd6, 0, 0, "R9 slot 6");
    host_read(6'h28, 0, 0, "R9 command");

    // R1 / R7 / R6 window contents
    lwrite(6'h00, 8'h3E);
    lwrite(6'h08, 8'hA5);
    lwrite(6'h1F, 8'hFF);
    lwrite(6'h20, 8'hC3);
    lwrite(6'h27, 8'h80);
    lwrite(6'h2C, 8'hCD);
    lwrite(6'h2D, 8'h12);
    lwrite(6'h34, 8'hCD);
    lwrite(6'h3C, 8'hCD);
    host_read(6'h00, 'h3E, 0, "R1 offset 0x00");
    host_read(6'h08, 'hA5, 0, "R1 offset 0x08");
    host_read(6'h1F, 'hFF, 0, "R1 offset 0x1F");
    host_read(6'h20, 'h43, 0, "R7 tone note 0x20");
    host_read(6'h27, 'h00, 0, "R7 tone note 0x27");
    host_read(6'h2C, 'hCD, 4, "R6 sequencer vector");
    host_read(6'h2D, 'h12, 0, "R6 vector low byte no event");
    host_read(6'h34, 'hCD, 2, "R6 receive vector");
    host_read(6'h3C, 'hCD, 1, "R6 modulation vector");

    // R8 one-shot command
    lwrite(6'h28, 8'h05);
    host_read(6'h28, 'h05, 0, "R8 command first read");
    host_read(6'h28, 'h00, 0, "R8 command cleared");
    lwrite(6'h28, 8'h09);
    host_read(6'h28, 'h09, 0, "R8 command reload");

    // R2 partial enables
    half_enable(1'b1);
    half_enable(1'b0);

    // R3 / R4 / R5 inbound mailbox
    host_write(6'h01, 8'h90);
    lread(3'd1, 'h90, 2, "R4 new set");
    lread(3'd1, 'h90, 0, "R4 new cleared");
    host_write(6'h03, 8'h11);
    host_write(6'h03, 8'h22);
    lread(3'd3, 'h22, 3, "R5 overrun set");
    lread(3'd3, 'h22, 0, "R5 overrun cleared");
    host_write(6'h02, 8'hFE);
    lread(3'd2, 'h00, 2, "R3 flag slot bit 0 only");
    host_write(6'h02, 8'h03);
    lread(3'd2, 'h01, 2, "R3 flag slot set");
    host_write(6'h10, 8'h77);
    host_write(6'h07, 8'h66);
    for (int s = 0; s < 7; s++) begin
      if (s == 0 || s == 4 || s == 5 || s == 6)
        lread(3'(s), 0, 0, "R3 out-of-range write ignored");
    end
    lread(3'd1, 'h90, 0, "R3 slot 1 untouched");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule